// File: doc/BRIEF.md
# GPIO edge-interrupt aggregator

This block watches a vector of already-synchronized GPIO pins and turns selected transitions into sticky status bits. Software picks which pins react to a low-to-high transition and which react to a high-to-low transition. Each choice is a separate mask. Each mask is changed through its own set port and its own clear port, so one pin can be changed without a read-modify-write. A recorded bit stays set until software writes a 1 to it.

The status word is split into groups of 16 pins. In banked operation, each group drives one level-sensitive interrupt line, and each line is gated by its own bit in a group-enable register. In direct operation, chosen at build time by a non-zero `DIRECT_N`, each of the lowest `DIRECT_N` pins drives its own interrupt output. Those outputs are gated only by group-enable bit 0, and the group lines stay low. Edge polarity comes from the same two masks in both operations.

Top module: `gpio_edge_irq_agg`

## Requirements
- R1: After reset, the rising mask, the falling mask, the status word and the group-enable register all read as zero, and every interrupt output is low.
- R2: A write to address 1 ORs the written 1s into the rising mask, and a write to address 2 removes them from it. Addresses 4 and 5 do the same for the falling mask. Written 0s leave those bits unchanged. Address 0 reads the rising mask, and address 3 reads the falling mask.
- R3: A pin whose synchronized input goes 0→1 with its rising-mask bit set, or 1→0 with its falling-mask bit set, sets its status bit (address 6, bit n = pin n). This happens on the second clock edge after the input changes. A transition on a pin with neither mask bit set never sets its status bit.
- R4: Writing to address 6 clears each status bit written as 1 and leaves each bit written as 0 unchanged.
- R5: When a new qualifying edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R6: In banked operation, group line g equals the OR of status bits [16g+15:16g] ANDed with group-enable bit g (address 7, bit g). The line stays high for as long as any such bit stays set.
- R7: In direct operation, output i (i < DIRECT_N) equals status bit i ANDed with group-enable bit 0. The other group-enable bits have no effect, status bits at or above DIRECT_N do not reach these outputs, and the group lines stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | NUM_PINS | Write data |
| reg_rdata | output | NUM_PINS | Read data for reg_addr (combinational) |
| pins_in | input | NUM_PINS | Synchronized pin levels |
| grp_irq | output | NUM_PINS/GROUP_W | Per-group interrupt lines (banked operation) |
| pin_irq | output | max(DIRECT_N,1) | Per-pin interrupt outputs (direct operation) |

## Verification
The bench builds two copies of the block. One uses the defaults (32 pins, groups of 16, DIRECT_N = 0); the other uses DIRECT_N = 4. Both copies share every input, so one stimulus stream exercises banked and direct routing side by side. The banked copy brings within reach the OR-and-gate behaviour of both 16-pin lines under mixed mask patterns. The direct copy shows that group-enable bit 1 and status bits above pin 3 cannot reach the per-pin outputs.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RA_RISE_MASK = 4'h0,
    RA_RISE_SET  = 4'h1,
    RA_RISE_CLR  = 4'h2,
    RA_FALL_MASK = 4'h3,
    RA_FALL_SET  = 4'h4,
    RA_FALL_CLR  = 4'h5,
    RA_STATUS    = 4'h6,
    RA_GRP_EN    = 4'h7
  } reg_addr_e;
endpackage

// File: rtl/gpio_edge_cfg.sv
module gpio_edge_cfg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask
);
  function automatic logic [W-1:0] apply_setclr(
    input logic [W-1:0] old, input logic s, input logic c, input logic [W-1:0] d);
    if (s)      return old | d;
    else if (c) return old & ~d;
    else        return old;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else        mask <= apply_setclr(mask, set_stb, clr_stb, wdata);
  end
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_in,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  output logic [W-1:0] edge_hit
);
  logic [W-1:0] samp_q;
  logic [W-1:0] prev_q;

  function automatic logic [W-1:0] find_edges(
    input logic [W-1:0] cur, input logic [W-1:0] old,
    input logic [W-1:0] ren, input logic [W-1:0] fen);
    return (cur & ~old & ren) | (~cur & old & fen);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      prev_q <= '0;
    end else begin
      samp_q <= pins_in;
      prev_q <= samp_q;
    end
  end

  assign edge_hit = find_edges(samp_q, prev_q, rise_en, fall_en);
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] edge_hit,
  input  logic [W-1:0] w1c_mask,
  output logic [W-1:0] status
);
  // A fresh edge is ORed in after the clear, so it survives a same-cycle clear.
  function automatic logic [W-1:0] next_status(
    input logic [W-1:0] old, input logic [W-1:0] clr, input logic [W-1:0] hit);
    return (old & ~clr) | hit;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= next_status(status, w1c_mask, edge_hit);
  end
endmodule

// File: rtl/gpio_irq_route.sv
module gpio_irq_route #(
  parameter int W          = 32,
  parameter int GROUP_W    = 16,
  parameter int NUM_GROUPS = 2,
  parameter int DIRECT_N   = 0,
  parameter int DIRECT_W   = 1
) (
  input  logic [W-1:0]          status,
  input  logic [NUM_GROUPS-1:0] grp_en,
  output logic [NUM_GROUPS-1:0] grp_irq,
  output logic [DIRECT_W-1:0]   pin_irq
);
  function automatic logic group_any(input logic [GROUP_W-1:0] bits, input logic en);
    return (|bits) & en;
  endfunction

  if (DIRECT_N == 0) begin : g_banked
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign grp_irq[g] = group_any(status[g*GROUP_W +: GROUP_W], grp_en[g]);
    end
    assign pin_irq = '0;
  end else begin : g_direct
    assign grp_irq = '0;
    for (genvar i = 0; i < DIRECT_N; i++) begin : g_pin
      assign pin_irq[i] = status[i] & grp_en[0];
    end
  end
endmodule

// File: rtl/gpio_edge_irq_agg.sv
module gpio_edge_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS   = 32,
  parameter int GROUP_W    = 16,
  parameter int DIRECT_N   = 0,
  localparam int NUM_GROUPS = NUM_PINS / GROUP_W,
  localparam int DIRECT_W   = (DIRECT_N > 0) ? DIRECT_N : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [REG_AW-1:0]     reg_addr,
  input  logic [NUM_PINS-1:0]   reg_wdata,
  output logic [NUM_PINS-1:0]   reg_rdata,
  input  logic [NUM_PINS-1:0]   pins_in,
  output logic [NUM_GROUPS-1:0] grp_irq,
  output logic [DIRECT_W-1:0]   pin_irq
);
  logic [NUM_PINS-1:0]   rise_en;
  logic [NUM_PINS-1:0]   fall_en;
  logic [NUM_PINS-1:0]   edge_hit;
  logic [NUM_PINS-1:0]   w1c_mask;
  logic [NUM_PINS-1:0]   status;
  logic [NUM_GROUPS-1:0] grp_en;

  logic wr_rise_set, wr_rise_clr, wr_fall_set, wr_fall_clr, wr_grp_en;

  assign wr_rise_set = reg_we && (reg_addr == RA_RISE_SET);
  assign wr_rise_clr = reg_we && (reg_addr == RA_RISE_CLR);
  assign wr_fall_set = reg_we && (reg_addr == RA_FALL_SET);
  assign wr_fall_clr = reg_we && (reg_addr == RA_FALL_CLR);
  assign wr_grp_en   = reg_we && (reg_addr == RA_GRP_EN);
  assign w1c_mask    = (reg_we && (reg_addr == RA_STATUS)) ? reg_wdata : '0;

  gpio_edge_cfg #(.W(NUM_PINS)) u_rise_cfg (
    .clk(clk), .rst_n(rst_n), .set_stb(wr_rise_set), .clr_stb(wr_rise_clr),
    .wdata(reg_wdata), .mask(rise_en));

  gpio_edge_cfg #(.W(NUM_PINS)) u_fall_cfg (
    .clk(clk), .rst_n(rst_n), .set_stb(wr_fall_set), .clr_stb(wr_fall_clr),
    .wdata(reg_wdata), .mask(fall_en));

  gpio_edge_detect #(.W(NUM_PINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in),
    .rise_en(rise_en), .fall_en(fall_en), .edge_hit(edge_hit));

  gpio_irq_status #(.W(NUM_PINS)) u_status (
    .clk(clk), .rst_n(rst_n), .edge_hit(edge_hit),
    .w1c_mask(w1c_mask), .status(status));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         grp_en <= '0;
    else if (wr_grp_en) grp_en <= reg_wdata[NUM_GROUPS-1:0];
  end

  gpio_irq_route #(
    .W(NUM_PINS), .GROUP_W(GROUP_W), .NUM_GROUPS(NUM_GROUPS),
    .DIRECT_N(DIRECT_N), .DIRECT_W(DIRECT_W)
  ) u_route (
    .status(status), .grp_en(grp_en), .grp_irq(grp_irq), .pin_irq(pin_irq));

  always_comb begin
    case (reg_addr)
      RA_RISE_MASK, RA_RISE_SET, RA_RISE_CLR: reg_rdata = rise_en;
      RA_FALL_MASK, RA_FALL_SET, RA_FALL_CLR: reg_rdata = fall_en;
      RA_STATUS:                              reg_rdata = status;
      RA_GRP_EN:                              reg_rdata = NUM_PINS'(grp_en);
      default:                                reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int NUM_PINS   = 32,
  parameter int GROUP_W    = 16,
  parameter int DIRECT_N   = 0,
  parameter int NUM_GROUPS = 2,
  parameter int DIRECT_W   = 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PINS-1:0]   rise_en,
  input logic [NUM_PINS-1:0]   fall_en,
  input logic [NUM_PINS-1:0]   edge_hit,
  input logic [NUM_PINS-1:0]   w1c_mask,
  input logic [NUM_PINS-1:0]   status,
  input logic [NUM_GROUPS-1:0] grp_en,
  input logic [NUM_GROUPS-1:0] grp_irq,
  input logic [DIRECT_W-1:0]   pin_irq
);
  AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((status & ~$past(status) & ~$past(edge_hit)) == '0)); // R3
  AST_SET_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((status & ~$past(status) & ~($past(rise_en) | $past(fall_en))) == '0)); // R3
  AST_CLEAR_NEEDS_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((~status & $past(status) & ~$past(w1c_mask)) == '0)); // R4
  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((status & $past(edge_hit)) == $past(edge_hit))); // R5

  if (DIRECT_N == 0) begin : g_banked
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      AST_GROUP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_en[g] && (|status[g*GROUP_W +: GROUP_W])) |-> grp_irq[g]); // R6
      AST_GROUP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_en[g] || !(|status[g*GROUP_W +: GROUP_W])) |-> !grp_irq[g]); // R6
    end
    AST_NO_PIN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |-> (pin_irq == '0)); // R6
  end else begin : g_direct
    for (genvar i = 0; i < DIRECT_N; i++) begin : g_pin
      AST_PIN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_en[0] && status[i]) |-> pin_irq[i]); // R7
      AST_PIN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!grp_en[0] || !status[i]) |-> !pin_irq[i]); // R7
    end
    AST_NO_GROUP_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |-> (grp_irq == '0)); // R7
  end
endmodule

bind gpio_edge_irq_agg gpio_edge_irq_chk #(
  .NUM_PINS(NUM_PINS), .GROUP_W(GROUP_W), .DIRECT_N(DIRECT_N),
  .NUM_GROUPS(NUM_GROUPS), .DIRECT_W(DIRECT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rise_en(rise_en), .fall_en(fall_en),
  .edge_hit(edge_hit), .w1c_mask(w1c_mask), .status(status),
  .grp_en(grp_en), .grp_irq(grp_irq), .pin_irq(pin_irq));

// File: tb/gpio_edge_irq_agg_tb.sv
module gpio_edge_irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] pins_in = '0;
  logic [31:0] rdata, rdata_d;
  logic [1:0]  grp, grp_d;
  logic [0:0]  pin;
  logic [3:0]  pin_d;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpio_edge_irq_agg u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .pins_in(pins_in),
    .grp_irq(grp), .pin_irq(pin));

  gpio_edge_irq_agg #(.DIRECT_N(4)) u_dut_dir (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_d), .pins_in(pins_in),
    .grp_irq(grp_d), .pin_irq(pin_d));

  // {pins driven, status expected} with rise mask 0F0F0F0F, fall mask 00FF00FF
  localparam logic [63:0] STEPS [0:6] = '{
    {32'hFFFF_FFFF, 32'h0F0F_0F0F},
    {32'h0000_0000, 32'h00FF_00FF},
    {32'h0000_FFFF, 32'h0000_0F0F},
    {32'hFFFF_0000, 32'h0F0F_00FF},
    {32'hFFFF_0000, 32'h0000_0000},
    {32'hF0F0_F0F0, 32'h000F_0000},
    {32'h0F0F_0F0F, 32'h0FFF_0FFF}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = rdata;
  endtask

  task automatic drive_pins(input logic [31:0] p);
    pins_in = p;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'h0, v); chk("R1", "rise mask", v, 32'h0);
    rd(4'h3, v); chk("R1", "fall mask", v, 32'h0);
    rd(4'h6, v); chk("R1", "status", v, 32'h0);
    rd(4'h7, v); chk("R1", "group enable", v, 32'h0);
    chk("R1", "grp_irq", {30'h0, grp}, 32'h0);
    chk("R1", "direct pin_irq", {28'h0, pin_d}, 32'h0);

    // R2 set/clear ports
    wr(4'h1, 32'h0F0F_0F0F); rd(4'h0, v); chk("R2", "rise set", v, 32'h0F0F_0F0F);
    wr(4'h1, 32'h0);         rd(4'h0, v); chk("R2", "rise set zeros", v, 32'h0F0F_0F0F);
    wr(4'h2, 32'h0000_000F); rd(4'h0, v); chk("R2", "rise clear", v, 32'h0F0F_0F00);
    wr(4'h2, 32'h0);         rd(4'h0, v); chk("R2", "rise clear zeros", v, 32'h0F0F_0F00);
    wr(4'h1, 32'h0000_000F); rd(4'h0, v); chk("R2", "rise restore", v, 32'h0F0F_0F0F);
    wr(4'h4, 32'h00FF_00FF); rd(4'h3, v); chk("R2", "fall set", v, 32'h00FF_00FF);
    wr(4'h5, 32'h0);         rd(4'h3, v); chk("R2", "fall clear zeros", v, 32'h00FF_00FF);
    wr(4'h7, 32'h3);

    // R3, R6, R4 table walk
    for (int i = 0; i < 7; i++) begin
      logic [31:0] exp_s;
      exp_s = STEPS[i][31:0];
      drive_pins(STEPS[i][63:32]);
      rd(4'h6, v); chk("R3", $sformatf("status step %0d", i), v, exp_s);
      chk("R6", $sformatf("grp_irq step %0d", i), {30'h0, grp},
          {30'h0, (|exp_s[31:16]), (|exp_s[15:0])});
      if (i < 6) begin
        wr(4'h6, 32'hFFFF_FFFF);
        rd(4'h6, v); chk("R4", $sformatf("clear all step %0d", i), v, 32'h0);
        chk("R6", "grp_irq low after clear", {30'h0, grp}, 32'h0);
      end
    end

    // R4 partial clear and zeros ignored
    wr(4'h6, 32'h0000_00FF); rd(4'h6, v); chk("R4", "partial clear", v, 32'h0FFF_0F00);
    wr(4'h6, 32'h0);         rd(4'h6, v); chk("R4", "zero write", v, 32'h0FFF_0F00);
    wr(4'h6, 32'hFFFF_FFFF); rd(4'h6, v); chk("R4", "full clear", v, 32'h0);

    // R5 edge and clear in same cycle
    drive_pins(32'h0F0F_0F0E);
    rd(4'h6, v); chk("R5", "bit0 set by fall", v, 32'h1);
    pins_in = 32'h0F0F_0F0F;
    @(negedge clk);
    wr(4'h6, 32'h0000_0001);
    rd(4'h6, v); chk("R5", "edge survives clear", v, 32'h1);
    chk("R5", "line still high", {30'h0, grp}, 32'h1);
    wr(4'h6, 32'h0000_0001);
    rd(4'h6, v); chk("R4", "later clear works", v, 32'h0);

    // R7 direct routing
    drive_pins(32'h0F0F_0F0B);
    chk("R7", "direct pin2", {28'h0, pin_d}, 32'h4);
    chk("R7", "direct grp lines low", {30'h0, grp_d}, 32'h0);
    chk("R6", "banked grp0", {30'h0, grp}, 32'h1);
    wr(4'h7, 32'h2);
    chk("R7", "enable bit1 has no effect", {28'h0, pin_d}, 32'h0);
    chk("R6", "grp0 gated", {30'h0, grp}, 32'h0);
    wr(4'h7, 32'h1);
    chk("R7", "enable bit0 restores", {28'h0, pin_d}, 32'h4);
    drive_pins(32'h0F0F_0F2B);
    rd(4'h6, v); chk("R3", "no rise mask, no flag", v, 32'h4);
    drive_pins(32'h0F0F_0F0B);
    rd(4'h6, v); chk("R3", "bit5 fall flagged", v, 32'h24);
    chk("R7", "bit5 not routed", {28'h0, pin_d}, 32'h4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule